// File: doc/BRIEF.md
# GF(2^m) multiply and divide unit

A multi-cycle arithmetic unit for binary polynomials and binary extension fields. A configuration register holds the reduction polynomial and its degree. Field operations therefore take two operands, as ordinary integer arithmetic does.

The unit offers six operations:
- field multiply modulo the configured polynomial;
- polynomial quotient;
- polynomial remainder;
- three views of the full carry-less product: low half, high half and reversed.

All six run on one shift-and-XOR datapath that handles one operand bit per cycle.

A caller loads operands A and B with an operation code on a one-cycle `start`. The unit spends one setup cycle and then XLEN iteration cycles. It then raises `done` for one cycle, with the result on `result`. The result stays valid until the next accepted start. `start` is ignored while the unit is busy.

Top module: `gfu_unit`

## Requirements
- R1: The polynomial (`cfg_poly`, bit `deg` set) and the degree (`cfg_deg`) are written together when `cfg_we` is high, and every later field multiply uses them. After reset they hold the values of the parameters RST_POLY and RST_DEG (default 0x11B, degree 8).
- R2: Op code 0 (field multiply) returns A·B reduced modulo the configured polynomial, for A and B below 2^deg. With 0x11B, 0x57·0x83 = 0xC1, 0x57·0x13 = 0xFE and 0x80·0x83 = 0x01. With 0xB (degree 3), 0x7·0x5 = 0x6.
- R3: Op code 1 returns the quotient q of the polynomial division of A (dividend) by B (divisor).
- R4: Op code 2 returns the remainder r of that division. A = q·B XOR r holds, and r < B for a nonzero B.
- R5: For B = 0, op code 1 returns 0 and op code 2 returns A, with the normal latency.
- R6: Op code 3 returns bits [XLEN-1:0] of the 2·XLEN-bit carry-less product of A and B.
- R7: Op code 4 returns bits [2·XLEN-1:XLEN] of that product.
- R8: Op code 5 returns bits [2·XLEN-2:XLEN-1] of that product.
- R9: `done` is a single-cycle pulse, XLEN+1 cycles after the clock edge that accepted `start`. `busy` is high from that acceptance until `done`, and low in the `done` cycle.
- R10: A `start` that arrives while `busy` is high is ignored. It neither changes the running operation nor begins a new one.
- R11: After reset, `busy` and `done` are low and `result` is 0.
- R12: Op codes 6 and 7 complete with the normal latency and return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write enable for the polynomial and degree |
| cfg_poly | input | XLEN | Reduction polynomial, including its top bit |
| cfg_deg | input | $clog2(XLEN) | Degree of the reduction polynomial |
| start | input | 1 | Request to begin an operation (accepted when idle) |
| op | input | 3 | Operation code (0 to 5, with 6 and 7 reserved) |
| opa | input | XLEN | Operand A (multiplicand or dividend) |
| opb | input | XLEN | Operand B (multiplier or divisor) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | XLEN | Result of the last completed operation |

## Verification
The bench builds the unit with XLEN = 32 and keeps the default reset polynomial 0x11B of degree 8. With this width the latency is 33 cycles, which keeps the run short. The width also lets short hand-written vectors reach the product bits at positions 31 and 32, where the high and reversed carry-less forms split. A divisor whose top bit is XLEN-1 is reachable as well. Both the byte field and the degree-3 field fit inside the 32-bit operands, and the reset polynomial is exercised before any configuration write.

// File: rtl/gfu_pkg.sv
package gfu_pkg;

   localparam logic [2:0] OP_GFMUL  = 3'd0;
   localparam logic [2:0] OP_GFDIV  = 3'd1;
   localparam logic [2:0] OP_GFMOD  = 3'd2;
   localparam logic [2:0] OP_CLMUL  = 3'd3;
   localparam logic [2:0] OP_CLMULH = 3'd4;
   localparam logic [2:0] OP_CLMULR = 3'd5;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_RUN   = 2'd2
   } gfu_state_e;

   function automatic logic op_is_div(input logic [2:0] code);
      return (code == OP_GFDIV) || (code == OP_GFMOD);
   endfunction

endpackage

// File: rtl/gfu_cfg.sv
module gfu_cfg #(
   parameter int XLEN = 64,
   parameter int DW = 6,
   parameter logic [XLEN-1:0] RST_POLY = 'h11B,
   parameter int RST_DEG = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [XLEN-1:0] poly_in,
   input  logic [DW-1:0]   deg_in,
   output logic [XLEN-1:0] poly_q,
   output logic [DW-1:0]   deg_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poly_q <= RST_POLY;
         deg_q  <= DW'(RST_DEG);
      end else if (we) begin
         poly_q <= poly_in;
         deg_q  <= deg_in;
      end
   end

endmodule

// File: rtl/gfu_msb.sv
module gfu_msb #(
   parameter int W = 64,
   parameter int IW = 6
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          is_zero
);

   logic [W-1:0] above;
   logic [W-1:0] top_hot;

   assign above[W-1] = 1'b0;
   generate
      for (genvar g = W - 2; g >= 0; g--) begin : g_chain
         assign above[g] = above[g+1] | vec[g+1];
      end
      for (genvar h = 0; h < W; h++) begin : g_hot
         assign top_hot[h] = vec[h] & ~above[h];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (top_hot[i]) idx = idx | IW'(i);
      end
   end

   assign is_zero = ~|vec;

endmodule

// File: rtl/gfu_step.sv
module gfu_step #(
   parameter int XLEN = 64,
   parameter int DW = 6
) (
   input  logic              div_mode,
   input  logic              field_mode,
   input  logic [2*XLEN-1:0] acc,
   input  logic [2*XLEN-1:0] mc,
   input  logic [XLEN-1:0]   mp,
   input  logic [XLEN-1:0]   poly,
   input  logic [DW-1:0]     deg,
   input  logic [DW-1:0]     dv,
   input  logic              zdiv,
   output logic [2*XLEN-1:0] acc_n,
   output logic [2*XLEN-1:0] mc_n,
   output logic [XLEN-1:0]   mp_n
);

   logic [XLEN-1:0]   rem_sh;
   logic              hit;
   logic [2*XLEN-1:0] mc_sh;

   always_comb begin
      acc_n  = acc;
      mc_n   = mc;
      mp_n   = mp;
      rem_sh = '0;
      hit    = 1'b0;
      mc_sh  = '0;
      if (div_mode) begin
         // bring the next dividend bit (MSB first) into the remainder
         rem_sh = {acc[XLEN-2:0], mp[XLEN-1]};
         hit    = !zdiv && rem_sh[dv];
         acc_n  = {{XLEN{1'b0}}, hit ? (rem_sh ^ mc[XLEN-1:0]) : rem_sh};
         // dividend leaves at the top, quotient bits enter at the bottom
         mp_n   = {mp[XLEN-2:0], hit};
      end else begin
         if (mp[0]) acc_n = acc ^ mc;
         mc_sh = mc << 1;
         if (field_mode && mc_sh[deg]) mc_sh = mc_sh ^ {{XLEN{1'b0}}, poly};
         mc_n  = mc_sh;
         mp_n  = mp >> 1;
      end
   end

endmodule

// File: rtl/gfu_ctrl.sv
module gfu_ctrl
   import gfu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic load,
   output logic setup,
   output logic step,
   output logic done
);

   localparam int CW = $clog2(XLEN);

   gfu_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;
   logic          last;

   assign load  = (state_q == ST_IDLE) && start;
   assign setup = (state_q == ST_SETUP);
   assign step  = (state_q == ST_RUN);
   assign last  = step && (cnt_q == CW'(XLEN - 1));
   assign busy  = (state_q != ST_IDLE);
   assign done  = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         case (state_q)
            ST_IDLE:  if (start) state_q <= ST_SETUP;
            ST_SETUP: begin
               state_q <= ST_RUN;
               cnt_q   <= '0;
            end
            ST_RUN: begin
               if (last) state_q <= ST_IDLE;
               else      cnt_q   <= cnt_q + 1'b1;
            end
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/gfu_unit.sv
module gfu_unit
   import gfu_pkg::*;
#(
   parameter int XLEN = 64,
   parameter logic [XLEN-1:0] RST_POLY = 'h11B,
   parameter int RST_DEG = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [XLEN-1:0]          cfg_poly,
   input  logic [$clog2(XLEN)-1:0]  cfg_deg,
   input  logic                     start,
   input  logic [2:0]               op,
   input  logic [XLEN-1:0]          opa,
   input  logic [XLEN-1:0]          opb,
   output logic                     busy,
   output logic                     done,
   output logic [XLEN-1:0]          result
);

   localparam int DW = $clog2(XLEN);
   localparam int W2 = 2 * XLEN;

   generate
      if (XLEN < 8) begin : g_bad_width
         $error("gfu_unit: XLEN must be at least 8");
      end
      if (RST_DEG < 1 || RST_DEG >= XLEN) begin : g_bad_deg
         $error("gfu_unit: RST_DEG must lie in 1..XLEN-1");
      end
   endgenerate

   logic [XLEN-1:0] poly_q;
   logic [DW-1:0]   deg_q;
   logic            load, setup, step;
   logic [W2-1:0]   acc_q, mc_q, acc_n, mc_n;
   logic [XLEN-1:0] mp_q, mp_n;
   logic [2:0]      op_q;
   logic [DW-1:0]   dv_q, dv_c;
   logic            zdiv_q, zdiv_c;

   gfu_cfg #(.XLEN(XLEN), .DW(DW), .RST_POLY(RST_POLY), .RST_DEG(RST_DEG)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .poly_in(cfg_poly), .deg_in(cfg_deg),
      .poly_q(poly_q), .deg_q(deg_q)
   );

   gfu_ctrl #(.XLEN(XLEN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
      .load(load), .setup(setup), .step(step), .done(done)
   );

   gfu_msb #(.W(XLEN), .IW(DW)) u_msb (
      .vec(mc_q[XLEN-1:0]), .idx(dv_c), .is_zero(zdiv_c)
   );

   gfu_step #(.XLEN(XLEN), .DW(DW)) u_step (
      .div_mode(op_is_div(op_q)), .field_mode(op_q == OP_GFMUL),
      .acc(acc_q), .mc(mc_q), .mp(mp_q), .poly(poly_q), .deg(deg_q),
      .dv(dv_q), .zdiv(zdiv_q),
      .acc_n(acc_n), .mc_n(mc_n), .mp_n(mp_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         mc_q   <= '0;
         mp_q   <= '0;
         op_q   <= OP_GFMUL;
         dv_q   <= '0;
         zdiv_q <= 1'b0;
      end else if (load) begin
         acc_q <= '0;
         op_q  <= op;
         if (op_is_div(op)) begin
            mc_q <= {{XLEN{1'b0}}, opb};
            mp_q <= opa;
         end else begin
            mc_q <= {{XLEN{1'b0}}, opa};
            mp_q <= opb;
         end
      end else if (setup) begin
         dv_q   <= dv_c;
         zdiv_q <= zdiv_c;
      end else if (step) begin
         acc_q <= acc_n;
         mc_q  <= mc_n;
         mp_q  <= mp_n;
      end
   end

   always_comb begin
      case (op_q)
         OP_GFMUL, OP_CLMUL, OP_GFMOD: result = acc_q[XLEN-1:0];
         OP_GFDIV:  result = mp_q;
         OP_CLMULH: result = acc_q[W2-1:XLEN];
         OP_CLMULR: result = acc_q[W2-2:XLEN-1];
         default:   result = '0;
      endcase
   end

endmodule

// File: rtl/gfu_unit_chk.sv
module gfu_unit_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [2:0]      op,
   input logic [XLEN-1:0] opa,
   input logic [XLEN-1:0] opb,
   input logic            busy,
   input logic            done,
   input logic [XLEN-1:0] result
);

   localparam int LW = $clog2(XLEN + 4) + 1;

   logic [XLEN-1:0] cap_a, cap_b;
   logic [2:0]      cap_op;
   logic [LW-1:0]   lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_a  <= '0;
         cap_b  <= '0;
         cap_op <= '0;
         lat_q  <= '0;
      end else begin
         if (start && !busy) begin
            cap_a  <= opa;
            cap_b  <= opb;
            cap_op <= op;
            lat_q  <= '0;
         end else if (busy && lat_q != '1) begin
            lat_q <= lat_q + 1'b1;
         end
      end
   end

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> lat_q == LW'(XLEN + 1)); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R10
   AST_ZDIV_QUOT: assert property (@(posedge clk) disable iff (!rst_n) (done && cap_op == 3'd1 && cap_b == '0) |-> result == '0); // R5
   AST_ZDIV_REM: assert property (@(posedge clk) disable iff (!rst_n) (done && cap_op == 3'd2 && cap_b == '0) |-> result == cap_a); // R5
   AST_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n) (done && cap_op == 3'd2 && cap_b != '0) |-> result < cap_b); // R4
   AST_CLMUL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && cap_op >= 3'd3 && cap_op <= 3'd5 && (cap_a == '0 || cap_b == '0)) |-> result == '0); // R6
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && cap_op >= 3'd6) |-> result == '0); // R12

endmodule

bind gfu_unit gfu_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
   .busy(busy), .done(done), .result(result)
);

// File: tb/gfu_unit_tb.sv
module gfu_unit_tb;

   localparam int W  = 32;
   localparam int DB = $clog2(W);
   localparam int NV = 20;

   typedef struct packed {
      logic [W-1:0]  poly;
      logic [DB-1:0] deg;
      logic [2:0]    op;
      logic [W-1:0]  a;
      logic [W-1:0]  b;
      logic [W-1:0]  exp;
   } vec_t;

   localparam vec_t TBL [NV] = '{
      '{32'hB,   5'd3, 3'd0, 32'h7,        32'h5,        32'h6},
      '{32'h11B, 5'd8, 3'd0, 32'h80,       32'h83,       32'h01},
      '{32'h11B, 5'd8, 3'd0, 32'h57,       32'h83,       32'hC1},
      '{32'h11B, 5'd8, 3'd0, 32'h57,       32'h13,       32'hFE},
      '{32'h11B, 5'd8, 3'd1, 32'hD,        32'h3,        32'h4},
      '{32'h11B, 5'd8, 3'd2, 32'hD,        32'h3,        32'h1},
      '{32'h11B, 5'd8, 3'd1, 32'hC0000001, 32'h80000000, 32'h1},
      '{32'h11B, 5'd8, 3'd2, 32'hC0000001, 32'h80000000, 32'h40000001},
      '{32'h11B, 5'd8, 3'd1, 32'h5,        32'h9,        32'h0},
      '{32'h11B, 5'd8, 3'd2, 32'h5,        32'h9,        32'h5},
      '{32'h11B, 5'd8, 3'd1, 32'hDEADBEEF, 32'h1,        32'hDEADBEEF},
      '{32'h11B, 5'd8, 3'd2, 32'hDEADBEEF, 32'h1,        32'h0},
      '{32'h11B, 5'd8, 3'd1, 32'hDEADBEEF, 32'h0,        32'h0},
      '{32'h11B, 5'd8, 3'd2, 32'hDEADBEEF, 32'h0,        32'hDEADBEEF},
      '{32'h11B, 5'd8, 3'd3, 32'h3,        32'h3,        32'h5},
      '{32'h11B, 5'd8, 3'd3, 32'h80000001, 32'h3,        32'h80000003},
      '{32'h11B, 5'd8, 3'd4, 32'h80000001, 32'h3,        32'h1},
      '{32'h11B, 5'd8, 3'd5, 32'h80000001, 32'h3,        32'h3},
      '{32'h11B, 5'd8, 3'd6, 32'h1234,     32'h5678,     32'h0},
      '{32'h11B, 5'd8, 3'd7, 32'hFFFF,     32'hFFFF,     32'h0}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_we;
   logic [W-1:0]  cfg_poly;
   logic [DB-1:0] cfg_deg;
   logic          start;
   logic [2:0]    op;
   logic [W-1:0]  opa, opb;
   logic          busy, done;
   logic [W-1:0]  result;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #2 clk = ~clk;

   gfu_unit #(.XLEN(W), .RST_POLY(32'h11B), .RST_DEG(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_poly(cfg_poly), .cfg_deg(cfg_deg),
      .start(start), .op(op), .opa(opa), .opb(opb),
      .busy(busy), .done(done), .result(result)
   );

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [2*W-1:0] ref_clmul(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [2*W-1:0] p = '0;
      for (int i = 0; i < W; i++) if (b[i]) p = p ^ ({{W{1'b0}}, a} << i);
      return p;
   endfunction

   task automatic ref_div(input logic [2*W-1:0] f, input logic [2*W-1:0] v,
                          output logic [2*W-1:0] q, output logic [2*W-1:0] r);
      int dv = -1;
      q = '0;
      r = f;
      for (int i = 0; i < 2*W; i++) if (v[i]) dv = i;
      if (dv >= 0) begin
         for (int i = 2*W-1; i >= dv; i--) begin
            if (r[i]) begin
               r = r ^ (v << (i - dv));
               q[i-dv] = 1'b1;
            end
         end
      end
   endtask

   function automatic string op_tag(input logic [2:0] code, input logic [W-1:0] b);
      case (code)
         3'd0: return "R2";
         3'd1: return (b == '0) ? "R5" : "R3";
         3'd2: return (b == '0) ? "R5" : "R4";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return "R12";
      endcase
   endfunction

   task automatic cfg_write(input logic [W-1:0] p, input logic [DB-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_poly = p; cfg_deg = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_op(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] res, output int lat);
      @(negedge clk);
      start = 1'b1; op = c; opa = a; opb = b;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!done && lat < 1000);
      res = result;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog actual=no_done expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0]   res;
      logic [2*W-1:0] q, r, p;
      logic [W-1:0]   q_dut, r_dut;
      int lat, extra;
      logic [W-1:0]   cur_poly;
      logic [DB-1:0]  cur_deg;

      rst_n = 1'b0; cfg_we = 1'b0; cfg_poly = '0; cfg_deg = '0;
      start = 1'b0; op = '0; opa = '0; opb = '0;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(busy == 1'b0, "R11 busy", W'(busy), '0);
      chk(done == 1'b0, "R11 done", W'(done), '0);
      chk(result == '0, "R11 result", result, '0);
      rst_n = 1'b1;

      // R1: reset polynomial 0x11B degree 8 is used before any write
      run_op(3'd0, 32'h57, 32'h83, res, lat);
      chk(res == 32'hC1, "R1 reset config", res, 32'hC1);
      // R9: latency and single-cycle pulse
      chk(lat == W + 1, "R9 latency", W'(lat), W'(W + 1));
      @(negedge clk);
      chk(done == 1'b0, "R9 pulse width", W'(done), '0);

      cur_poly = 32'h11B; cur_deg = 5'd8;
      foreach (TBL[k]) begin
         if (TBL[k].poly != cur_poly || TBL[k].deg != cur_deg) begin
            cfg_write(TBL[k].poly, TBL[k].deg); // R1: new configuration
            cur_poly = TBL[k].poly; cur_deg = TBL[k].deg;
         end
         run_op(TBL[k].op, TBL[k].a, TBL[k].b, res, lat);
         chk(res == TBL[k].exp, op_tag(TBL[k].op, TBL[k].b), res, TBL[k].exp);
         chk(lat == W + 1, "R9 table latency", W'(lat), W'(W + 1));
      end

      // R1: same operands, a degree-3 field after rewriting the configuration
      cfg_write(32'hB, 5'd3);
      run_op(3'd0, 32'h7, 32'h5, res, lat);
      chk(res == 32'h6, "R1 rewritten config", res, 32'h6);
      cfg_write(32'h11B, 5'd8);

      // R10: start while busy is ignored
      @(negedge clk);
      start = 1'b1; op = 3'd0; opa = 32'h57; opb = 32'h13;
      @(posedge clk);
      @(negedge clk);
      op = 3'd3; opa = 32'hFFFFFFFF; opb = 32'hFFFFFFFF;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         if (lat == 4) start = 1'b0;
      end while (!done && lat < 1000);
      chk(result == 32'hFE, "R10 result kept", result, 32'hFE);
      chk(lat == W + 1, "R10 latency unchanged", W'(lat), W'(W + 1));
      extra = 0;
      for (int i = 0; i < W + 4; i++) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk(extra == 0, "R10 no second op", W'(extra), '0);

      // random operands against independent models
      for (int it = 0; it < 12; it++) begin
         logic [W-1:0] a, b;
         a = $urandom();
         b = $urandom() >> (it % 20);
         p = ref_clmul(a, b);
         run_op(3'd3, a, b, res, lat);
         chk(res == p[W-1:0], "R6 random", res, p[W-1:0]);
         run_op(3'd4, a, b, res, lat);
         chk(res == p[2*W-1:W], "R7 random", res, p[2*W-1:W]);
         run_op(3'd5, a, b, res, lat);
         chk(res == p[2*W-2:W-1], "R8 random", res, p[2*W-2:W-1]);
         ref_div({{W{1'b0}}, a}, {{W{1'b0}}, b}, q, r);
         run_op(3'd1, a, b, q_dut, lat);
         chk(q_dut == q[W-1:0], "R3 random", q_dut, q[W-1:0]);
         run_op(3'd2, a, b, r_dut, lat);
         chk(r_dut == r[W-1:0], "R4 random", r_dut, r[W-1:0]);
         p = ref_clmul(q_dut, b) ^ {{W{1'b0}}, r_dut};
         chk(p[W-1:0] == a && p[2*W-1:W] == '0, "R4 identity", p[W-1:0], a);
         a = a & 32'hFF;
         b = b & 32'hFF;
         ref_div(ref_clmul(a, b), 64'h11B, q, r);
         run_op(3'd0, a, b, res, lat);
         chk(res == r[W-1:0], "R2 random", res, r[W-1:0]);
      end

      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule